// File: doc/BRIEF.md
# Tagged-Command I2C Bus Master

This block is an I2C bus controller that runs a transaction from a stream of 16-bit command words instead of from register writes. Each word carries an operation code in bits 11:8 and a byte in bits 7:0. Bits 15:12 must be zero. One word opens the bus with a START and sends an address byte. Another sends a data byte and then keeps the bus held. A third sends a data byte and closes the bus with STOP. A receive word names how many bytes to read. The controller drives open-drain enables for SCL and SDA, samples the acknowledge bit, and returns every received byte as a tagged 16-bit word.

Software or a DMA engine writes the command words through a valid/ready stream. A consumer drains the receive words through a second valid/ready stream. The controller never runs ahead of either stream. When the next command has not arrived, or a received word has not been taken, it parks the bus with SCL held low. The bit rate comes from a divider input. With no clock stretching, every SCL high or low phase lasts `div + 3` clock cycles, so one SCL period is `2*(div+3)` cycles. That setting covers standard and fast mode.

Top module: `tagi2c_master`

## Requirements
- R1: After reset, and whenever the bus is idle, both line enables are released, `bus_active` is 0, `cmd_ready` is 1, `rx_valid` is 0 and `nack_err` is 0.
- R2: A word with code 1 in bits 11:8 opens the bus when it is idle. SDA falls while SCL is high. The controller then shifts out the word's byte, most significant bit first, as 8 data clocks and one acknowledge clock. Bit 0 of that byte is the read/write flag (1 = read).
- R3: With no clock stretching, SCL high and low phases in a bit last exactly `div + 3` clock cycles each.
- R4: A word with code 2 sends its byte. After the acknowledge clock, the bus stays active with SCL held low until the next word arrives.
- R5: A word with code 3 sends its byte. After an acknowledged ninth clock, the controller issues STOP: SDA rises while SCL is high. The bus then returns to idle.
- R6: A word with code 4 reads as many bytes as its byte value. A value of 0 means 256 bytes. The controller acknowledges every byte except the last. It leaves the last byte unacknowledged (NACK) and then issues STOP.
- R7: Each received byte is output as `{4'h0, tag, byte}`. The tag is 2, or 3 for the final byte of the read. The word holds steady until `rx_ready` is high. While it is pending, the next byte does not start and SCL stays low.
- R8: A high SDA on the ninth clock of any byte the controller sent sets `nack_err` and triggers STOP. While `nack_err` is set, every incoming word is accepted and dropped without bus activity. `err_clr` clears the flag.
- R9: SDA changes while SCL is high only to form START or STOP.
- R10: A code-1 word that arrives while the bus is active produces a repeated START followed by its address byte.
- R11: A word whose bits 15:12 are nonzero, or whose code is not 1 to 4, is dropped while the bus is held. While the bus is idle, every word that is not code 1 is dropped.
- R12: `bus_active` is 1 from the START until the bus-free time after STOP has elapsed.
- R13: When a device holds SCL low after the controller releases it, the high-phase count does not begin until SCL is actually high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| div | input | 8 | Phase divider; a phase lasts div+3 cycles |
| cmd_data | input | 16 | Command word: code in 11:8, byte in 7:0 |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word taken this cycle |
| rx_data | output | 16 | Received word: tag in 11:8, byte in 7:0 |
| rx_valid | output | 1 | Received word pending |
| rx_ready | input | 1 | Consumer takes the received word |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Sensed SCL level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |
| nack_err | output | 1 | Sticky flag for a missing acknowledge |
| err_clr | input | 1 | Clears `nack_err` |
| bus_active | output | 1 | Transaction in progress |

## Verification
Most faults in the bit counter or the shift register show up within the same byte. A device on the bus sees a wrong byte value, or a ninth clock in the wrong place. The scoreboard compares every START, STOP, byte and acknowledge it observes, so such a fault is caught at the first bad edge. A divider or phase fault shows up as a measured SCL high or low width different from `div+3` on the very next bit. A fault in the read counter or the acknowledge choice moves the NACK to a different byte. That gives a wrong tag on a returned word, or an extra or missing byte before STOP. The 256-byte read exposes a count that wraps wrongly. A fault in the error or parking logic shows up as bus activity when none is expected. It can also show up as SCL released while a word is still pending.

// File: rtl/tagi2c_master.sv
module tagi2c_master #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div,
  input  logic [15:0]     cmd_data,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  output logic [15:0]     rx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic            scl_oe,
  input  logic            scl_in,
  output logic            sda_oe,
  input  logic            sda_in,
  output logic            nack_err,
  input  logic            err_clr,
  output logic            bus_active
);
  localparam logic [3:0] T_START = 4'd1, T_DATA = 4'd2, T_LAST = 4'd3, T_RECV = 4'd4;
  localparam logic [3:0] S_IDLE = 4'd0, S_RSL = 4'd1, S_RSH = 4'd2, S_STA = 4'd3,
                         S_BIT = 4'd4, S_WAIT = 4'd5, S_RXW = 4'd6, S_SPL = 4'd7,
                         S_SPH = 4'd8, S_SPE = 4'd9;

  logic [3:0]  st, bitn;
  logic [DIVW:0] cnt;
  logic        ph, rd, last, sda_lo;
  logic [7:0]  sh;
  logic [8:0]  left;

  wire [DIVW:0] hp     = {1'b0, div} + (DIVW+1)'(3);
  wire [3:0]    tag    = (cmd_data[15:12] == 4'd0) ? cmd_data[11:8] : 4'hF;
  wire [7:0]    cbyte  = cmd_data[7:0];
  wire          run    = !(st == S_IDLE || st == S_WAIT || st == S_RXW);
  wire          hold   = !scl_oe && !scl_in;
  wire          tick   = run && !hold && (cnt == hp - 1'b1);
  wire          mid    = run && (cnt == (hp >> 1));
  wire          take   = cmd_valid && cmd_ready;
  wire          lastrd = (left == 9'd1);
  wire [7:0]    rbyte  = {sh[6:0], sda_in};

  assign cmd_ready  = (st == S_IDLE) || (st == S_WAIT);
  assign bus_active = (st != S_IDLE);
  assign sda_oe     = sda_lo;
  assign scl_oe     = (st == S_RSL) || (st == S_BIT && !ph) || (st == S_WAIT) ||
                      (st == S_RXW) || (st == S_SPL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ph <= 1'b0; bitn <= '0; sh <= '0; rd <= 1'b0;
      last <= 1'b0; left <= '0; sda_lo <= 1'b0; rx_valid <= 1'b0;
      rx_data <= '0; nack_err <= 1'b0;
    end else begin
      if (!run || tick) cnt <= '0;
      else if (!hold)   cnt <= cnt + 1'b1;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (err_clr) nack_err <= 1'b0;
      case (st)
        S_IDLE: begin
          sda_lo <= 1'b0;
          if (take && !nack_err && tag == T_START) begin
            sh <= cbyte; sda_lo <= 1'b1; st <= S_STA;
          end
        end
        S_WAIT: if (take) begin
          case (tag)
            T_START: begin sh <= cbyte; st <= S_RSL; end
            T_DATA, T_LAST: begin
              sh <= cbyte; rd <= 1'b0; last <= (tag == T_LAST);
              st <= S_BIT; ph <= 1'b0; bitn <= '0;
            end
            T_RECV: begin
              rd <= 1'b1; left <= (cbyte == 8'd0) ? 9'd256 : {1'b0, cbyte};
              st <= S_BIT; ph <= 1'b0; bitn <= '0;
            end
            default: ;
          endcase
        end
        S_RSL: begin
          if (mid) sda_lo <= 1'b0;
          if (tick) st <= S_RSH;
        end
        S_RSH: if (tick) begin st <= S_STA; sda_lo <= 1'b1; end
        S_STA: if (tick) begin
          st <= S_BIT; ph <= 1'b0; bitn <= '0; rd <= 1'b0; last <= 1'b0;
        end
        S_BIT: begin
          if (!ph && mid)
            sda_lo <= (bitn == 4'd8) ? (rd && !lastrd) : (!rd && !sh[7]);
          if (tick && !ph) ph <= 1'b1;
          if (tick && ph) begin
            ph <= 1'b0;
            if (bitn != 4'd8) begin
              sh <= rbyte; bitn <= bitn + 4'd1;
              if (rd && bitn == 4'd7) begin
                rx_valid <= 1'b1;
                rx_data  <= {4'h0, lastrd ? T_LAST : T_DATA, rbyte};
              end
            end else if (rd) begin
              left <= left - 9'd1;
              st   <= lastrd ? S_SPL : S_RXW;
            end else if (sda_in) begin
              nack_err <= 1'b1; st <= S_SPL;
            end else begin
              st <= last ? S_SPL : S_WAIT;
            end
          end
        end
        S_RXW: if (!rx_valid) begin st <= S_BIT; ph <= 1'b0; bitn <= '0; end
        S_SPL: begin
          if (mid) sda_lo <= 1'b1;
          if (tick) st <= S_SPH;
        end
        S_SPH: if (tick) begin st <= S_SPE; sda_lo <= 1'b0; end
        S_SPE: if (tick) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tagi2c_master_chk.sv
module tagi2c_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        bus_active,
  input logic        cmd_ready,
  input logic        nack_err,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [15:0] rx_data,
  input logic [3:0]  st
);
  localparam logic [3:0] C_STA = 4'd3, C_RXW = 4'd6, C_SPE = 4'd9;

  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_active |-> (!scl_oe && !sda_oe));

  assert_sda_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> (st == C_STA || st == C_SPE));

  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_rx_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && st == C_RXW) |-> scl_oe);

  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_err && cmd_ready) |-> !bus_active);

  assert_nack_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> (bus_active && scl_oe));
endmodule

bind tagi2c_master tagi2c_master_chk u_chk (.*);

// File: tb/tagi2c_master_test.sv
module tagi2c_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int STRETCH = 20;
  localparam int EV_START = 32'h100, EV_STOP = 32'h300;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  div;
  logic [15:0] cmd_data, rx_data;
  logic cmd_valid, cmd_ready, rx_valid, rx_rdy;
  logic scl_oe, sda_oe, nack_err, err_clr, bus_active;
  logic sl_scl_lo = 1'b0, sl_sda_lo = 1'b0;
  logic scl, sda;
  assign scl = !scl_oe && !sl_scl_lo;
  assign sda = !sda_oe && !sl_sda_lo;

  tagi2c_master uut (
    .clk(clk), .rst_n(rst_n), .div(div), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_rdy),
    .scl_oe(scl_oe), .scl_in(scl), .sda_oe(sda_oe), .sda_in(sda),
    .nack_err(nack_err), .err_clr(err_clr), .bus_active(bus_active));

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int exp_bus[$];
  logic [15:0] exp_rx[$];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string ev_req(input int ev);
    case (ev[10:8])
      3'd1: return "R2 start";
      3'd2: return "R4 byte";
      3'd3: return "R5 stop";
      default: return "R6 read-ack";
    endcase
  endfunction

  task automatic got_ev(input int ev);
    int e;
    checks++;
    if (exp_bus.size() == 0) begin
      fails++;
      $display("FAIL %s unexpected actual=%0h expected=none", ev_req(ev), ev);
    end else begin
      e = exp_bus.pop_front();
      if (e != ev) begin
        fails++;
        $display("FAIL %s actual=%0h expected=%0h", ev_req(e), ev, e);
      end
    end
  endtask

  // Device model and bus monitor
  logic pscl, psda, s_c, s_d, is_addr, go_tx, tx, m_ack, ack, stretch_en;
  logic [7:0] rxsh, txb;
  int bitc, hi_len, lo_len, last_hi, last_lo, str_cnt;

  always @(negedge clk) begin
    if (!rst_n) begin
      pscl = 1; psda = 1; bitc = 0; is_addr = 0; go_tx = 0; tx = 0; m_ack = 0;
      hi_len = 0; lo_len = 0; last_hi = 0; last_lo = 0; str_cnt = 0; txb = 8'hA0;
      rxsh = 0; sl_scl_lo = 0; sl_sda_lo = 0;
    end else begin
      if (str_cnt > 0) begin
        str_cnt--;
        if (str_cnt == 0) sl_scl_lo = 0;
      end
      s_c = !scl_oe && !sl_scl_lo;
      s_d = !sda_oe && !sl_sda_lo;
      if (pscl && s_c && psda && !s_d) begin
        got_ev(EV_START); bitc = 0; is_addr = 1; tx = 0; go_tx = 0; txb = 8'hA0;
      end else if (pscl && s_c && !psda && s_d) begin
        got_ev(EV_STOP); bitc = 0; tx = 0; go_tx = 0; sl_sda_lo = 0;
      end else if (!pscl && s_c) begin
        last_lo = lo_len; lo_len = 0;
        if (bitc < 8) begin rxsh = {rxsh[6:0], s_d}; bitc++; end
        else if (bitc == 8) begin
          if (tx) begin m_ack = !s_d; got_ev(32'h400 | (s_d ? 1 : 0)); end
          bitc = 9;
        end
      end else if (pscl && !s_c) begin
        last_hi = hi_len; hi_len = 0;
        if (stretch_en) begin sl_scl_lo = 1; str_cnt = STRETCH; end
        if (bitc == 8) begin
          if (!tx) begin
            got_ev(32'h200 | int'(rxsh));
            ack = is_addr ? (rxsh[7:1] == 7'h50) : 1'b1;
            sl_sda_lo = ack;
            go_tx = is_addr && ack && rxsh[0];
          end else sl_sda_lo = 0;
        end else if (bitc == 9) begin
          bitc = 0; is_addr = 0;
          if (go_tx) begin tx = 1; go_tx = 0; sl_sda_lo = !txb[7]; end
          else if (tx && m_ack) begin txb = txb + 8'd1; sl_sda_lo = !txb[7]; end
          else begin tx = 0; sl_sda_lo = 0; end
        end else if (tx && bitc > 0) sl_sda_lo = !txb[7-bitc];
      end
      s_c = !scl_oe && !sl_scl_lo;
      s_d = !sda_oe && !sl_sda_lo;
      if (s_c) hi_len++; else lo_len++;
      pscl = s_c; psda = s_d;
    end
  end

  // Receive-stream monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_rdy) begin
      checks++;
      if (exp_rx.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected rx actual=%0h expected=none", rx_data);
      end else begin
        logic [15:0] e;
        e = exp_rx.pop_front();
        if (e != rx_data) begin
          fails++;
          $display("FAIL R7 rx word actual=%0h expected=%0h", rx_data, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      fails++;
      $display("FAIL R12 watchdog actual=%0d expected=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic push_cmd(input logic [15:0] c);
    @(negedge clk);
    cmd_data = c; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (bus_active || exp_bus.size() != 0 || exp_rx.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic ex(input int ev); exp_bus.push_back(ev); endtask
  task automatic exw(input logic [7:0] b); exp_bus.push_back(32'h200 | int'(b)); endtask

  initial begin
    div = 8'd5; cmd_valid = 0; cmd_data = 0; err_clr = 0; rx_rdy = 1; stretch_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 bus_active", bus_active, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 nack_err", nack_err, 0);

    // R2 R4 R5 R3: write with parked bus between entries, div=5
    ex(EV_START); exw(8'hA0); exw(8'h11); exw(8'h22); ex(EV_STOP);
    push_cmd(16'h01A0); push_cmd(16'h0211);
    while (exp_bus.size() > 2) @(negedge clk);
    repeat (100) @(negedge clk);
    chk("R12 active while parked", bus_active, 1);
    chk("R4 scl held low while parked", scl, 0);
    push_cmd(16'h0322);
    wait_done();
    chk("R3 high phase div=5", last_hi, 8);
    chk("R3 low phase div=5", last_lo, 8);
    chk("R5 idle after stop", bus_active, 0);

    // R6 R7: three-byte read, div=0
    div = 8'd0;
    ex(EV_START); exw(8'hA1); ex(32'h400); ex(32'h400); ex(32'h401); ex(EV_STOP);
    exp_rx.push_back(16'h02A0); exp_rx.push_back(16'h02A1); exp_rx.push_back(16'h03A2);
    push_cmd(16'h01A1); push_cmd(16'h0403);
    wait_done();
    chk("R3 high phase div=0", last_hi, 3);

    // R10: repeated start into a one-byte read
    ex(EV_START); exw(8'hA0); exw(8'h05); ex(EV_START); exw(8'hA1); ex(32'h401); ex(EV_STOP);
    exp_rx.push_back(16'h03A0);
    push_cmd(16'h01A0); push_cmd(16'h0205); push_cmd(16'h01A1); push_cmd(16'h0401);
    wait_done();

    // R11: dropped words, idle and parked
    push_cmd(16'h0255);
    repeat (30) @(negedge clk);
    chk("R11 idle non-start dropped", bus_active, 0);
    ex(EV_START); exw(8'hA0); exw(8'h44); ex(EV_STOP);
    push_cmd(16'h01A0); push_cmd(16'h0777); push_cmd(16'h1233); push_cmd(16'h0344);
    wait_done();

    // R7: receive back-pressure parks the bus
    rx_rdy = 0;
    ex(EV_START); exw(8'hA1); ex(32'h400); ex(32'h401); ex(EV_STOP);
    exp_rx.push_back(16'h02A0); exp_rx.push_back(16'h03A1);
    push_cmd(16'h01A1); push_cmd(16'h0402);
    while (!rx_valid) @(negedge clk);
    repeat (200) @(negedge clk);
    chk("R7 word held", rx_valid, 1);
    chk("R7 word value held", rx_data, 16'h02A0);
    chk("R7 scl parked low", scl, 0);
    chk("R12 active during stall", bus_active, 1);
    rx_rdy = 1;
    wait_done();

    // R8: address not acknowledged
    ex(EV_START); exw(8'h66); ex(EV_STOP);
    push_cmd(16'h0166);
    wait_done();
    chk("R8 nack flag set", nack_err, 1);
    push_cmd(16'h01A0); push_cmd(16'h0211);
    repeat (40) @(negedge clk);
    chk("R8 flushed words cause no activity", bus_active, 0);
    chk("R8 flag sticky", nack_err, 1);
    err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
    chk("R8 flag cleared", nack_err, 0);
    ex(EV_START); exw(8'hA0); exw(8'h99); ex(EV_STOP);
    push_cmd(16'h01A0); push_cmd(16'h0399);
    wait_done();

    // R13: device stretches every low phase
    stretch_en = 1;
    ex(EV_START); exw(8'hA0); exw(8'h5A); ex(EV_STOP);
    push_cmd(16'h01A0); push_cmd(16'h035A);
    wait_done();
    stretch_en = 0;
    chk("R13 high phase after stretch", last_hi, 3);

    // R6: count 0 reads 256 bytes
    ex(EV_START); exw(8'hA1);
    for (int i = 0; i < 255; i++) ex(32'h400);
    ex(32'h401); ex(EV_STOP);
    for (int i = 0; i < 256; i++)
      exp_rx.push_back({4'h0, (i == 255) ? 4'h3 : 4'h2, 8'(8'hA0 + i)});
    push_cmd(16'h01A1); push_cmd(16'h0400);
    wait_done();
    chk("R6 all 256 words consumed", exp_rx.size(), 0);
    chk("R1 idle after long read", sda_oe | scl_oe, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule